// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a simple synchronous request/acknowledge bus and an external asynchronous static RAM with an 18-bit address and an 8-bit data path. A host raises `req` with a direction flag, an address and write data. The controller accepts the request only when it is idle. It then drives the RAM's active-low chip-select, output-enable and write-strobe pins in a fixed cycle pattern, so that every access meets minimum pulse, setup and float times. These times are given as parameters in system clock cycles. The block finishes each access with a single-cycle `ack`, and with `rvalid` as well for a read.

The RAM data pins are a tri-state bus. The block brings it out as three port groups: a driven value, a per-bit drive enable and the sampled input. Between accesses the RAM is deselected, so it sits in standby with its pins floating. Writes keep output enable high for their whole length, which allows the shorter write-strobe pulse. The controller does not drive the bus until the RAM has had time to float its pins. This applies after the strobe falls and after a read releases output enable.

Top module: `sram_bridge`

## Requirements
- R1: While `rst_n` is low, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is all zeros, and `ack` and `rvalid` are 0.
- R2: In every cycle with `mem_ce_n` high, `mem_oe_n` and `mem_we_n` are high and `mem_dq_oe` is zero. The RAM is deselected whenever no access is in progress.
- R3: A read holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for exactly T_RD cycles. `rdata` takes the value on `mem_dq_i` in the last of those cycles. `ack` and `rvalid` then pulse together for one cycle while the chip is deselected.
- R4: A write holds `mem_ce_n` low for T_WLZ+T_DS+1 cycles and `mem_we_n` low for the first T_WLZ+T_DS of them. `mem_oe_n` stays high throughout the write, and output enable and write strobe are never low together.
- R5: During a write, the bus is not driven in the first T_WLZ cycles after `mem_we_n` falls. The latched write data is driven for the last T_DS strobe-low cycles and for the one cycle after the strobe rises, so T_DS+1 driven cycles in all.
- R6: A write ends with a one-cycle `ack` and `rvalid` low. `ack` is never high in two consecutive cycles.
- R7: A write requested straight after a read's `ack` drops `mem_we_n` only after output enable has been high for T_HZ+2 cycles. Any other access requested straight after an `ack` starts after exactly 2 deselected cycles.
- R8: Address and write data are latched when the request is accepted. Changes on `addr` and `wdata` while an access is in progress do not affect `mem_addr` or the stored data, and `mem_addr` is stable while `mem_ce_n` is low.
- R9: `rdata` keeps the last read value across writes and changes only when a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, held until `ack` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Access address |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last read data |
| rvalid | output | 1 | High with `ack` for a read |
| mem_addr | output | 18 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_o | output | 8 | Value driven onto RAM data pins |
| mem_dq_oe | output | 8 | Per-bit drive enable for RAM data pins |
| mem_dq_i | input | 8 | Value sampled from RAM data pins |

## Verification
The bench measures the low-time of each strobe and the number of driven-bus cycles for every access. A design that drives the bus at the strobe's falling edge is reported as contention. A design that drops the data together with the strobe's rising edge fails the hold count. Back-to-back pairs measure the deselected gap. A read followed by a write that skips the float recovery shows a gap one or more cycles short. The bench also corrupts `addr` and `wdata` mid-access and then reads the locations back, which exposes a design that samples the request late. A design that clobbers `rdata` on a write fails the check that the held read value stays unchanged.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_READ   = 3'd1,
      ST_WFLOAT = 3'd2,
      ST_WDRIVE = 3'd3,
      ST_WEND   = 3'd4
   } seq_state_e;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic drive;
   } pin_ctl_t;

   localparam pin_ctl_t PINS_STANDBY = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

   function automatic pin_ctl_t pins_for(input seq_state_e s);
      pin_ctl_t p;
      p = PINS_STANDBY;
      case (s)
         ST_READ: begin
            p.ce_n = 1'b0;
            p.oe_n = 1'b0;
         end
         ST_WFLOAT: begin
            p.ce_n = 1'b0;
            p.we_n = 1'b0;
         end
         ST_WDRIVE: begin
            p.ce_n  = 1'b0;
            p.we_n  = 1'b0;
            p.drive = 1'b1;
         end
         ST_WEND: begin
            p.ce_n  = 1'b0;
            p.drive = 1'b1;
         end
         default: p = PINS_STANDBY;
      endcase
      return p;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_bridge_timer.sv
module sram_bridge_timer #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   input  logic         dec,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= val;
      end else if (dec && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_bridge_seq.sv
module sram_bridge_seq
   import sram_bridge_pkg::*;
#(
   parameter int T_RD  = 1,
   parameter int T_WLZ = 1,
   parameter int T_DS  = 1,
   parameter int T_HZ  = 1,
   parameter int T_WP  = 1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req,
   input  logic     req_we,
   output logic     accept,
   output logic     capture,
   output pin_ctl_t pins,
   output logic     ack,
   output logic     rvalid
);

   localparam int TMAX = max_of(max_of(T_RD, T_WLZ), max_of(T_DS, T_HZ));
   localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX + 1);

   if (T_RD < 1 || T_WLZ < 1 || T_DS < 1) begin : g_bad_min
      $error("sram_bridge_seq: T_RD, T_WLZ and T_DS must be at least 1");
   end
   if (T_HZ < 0) begin : g_bad_hz
      $error("sram_bridge_seq: T_HZ must not be negative");
   end
   if (T_WLZ + T_DS < T_WP) begin : g_bad_wp
      $error("sram_bridge_seq: strobe-low time T_WLZ+T_DS is shorter than T_WP");
   end

   seq_state_e state_q, state_d;
   pin_ctl_t   pins_q;
   logic       ack_q, rvalid_q;
   logic       ph_load, ph_zero;
   logic [CW-1:0] ph_val;
   logic       rec_zero, done;

   sram_bridge_timer #(.W(CW)) i_phase (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ph_load),
      .val  (ph_val),
      .dec  (1'b1),
      .zero (ph_zero)
   );

   sram_bridge_timer #(.W(CW)) i_recover (
      .clk  (clk),
      .rst_n(rst_n),
      .load (capture),
      .val  (CW'(T_HZ)),
      .dec  (!ack_q),
      .zero (rec_zero)
   );

   always_comb begin
      state_d = state_q;
      ph_load = 1'b0;
      ph_val  = '0;
      accept  = 1'b0;
      capture = 1'b0;
      done    = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req && !ack_q && !(req_we && !rec_zero)) begin
               accept  = 1'b1;
               ph_load = 1'b1;
               if (req_we) begin
                  state_d = ST_WFLOAT;
                  ph_val  = CW'(T_WLZ - 1);
               end else begin
                  state_d = ST_READ;
                  ph_val  = CW'(T_RD - 1);
               end
            end
         end
         ST_READ: begin
            if (ph_zero) begin
               capture = 1'b1;
               done    = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_WFLOAT: begin
            if (ph_zero) begin
               state_d = ST_WDRIVE;
               ph_load = 1'b1;
               ph_val  = CW'(T_DS - 1);
            end
         end
         ST_WDRIVE: begin
            if (ph_zero) state_d = ST_WEND;
         end
         ST_WEND: begin
            done    = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         pins_q   <= PINS_STANDBY;
         ack_q    <= 1'b0;
         rvalid_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         pins_q   <= pins_for(state_d);
         ack_q    <= done;
         rvalid_q <= capture;
      end
   end

   assign pins   = pins_q;
   assign ack    = ack_q;
   assign rvalid = rvalid_q;

   assert_ack_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   assert_rvalid_with_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> ack);

   assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pins.we_n |-> pins.oe_n);

   assert_oe_settled_before_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pins.we_n) |-> ($past(pins.oe_n) && $past(pins.oe_n, 2)));

   assert_deselect_on_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (pins.ce_n && pins.oe_n && pins.we_n && !pins.drive));

endmodule

// File: rtl/sram_bridge_dpath.sv
module sram_bridge_dpath #(
   parameter int AW = 18,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          capture,
   input  logic          drive,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] mem_dq_i,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_o,
   output logic [DW-1:0] mem_dq_oe,
   output logic [DW-1:0] rdata
);

   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("sram_bridge_dpath: widths must be positive");
   end

   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q, rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= addr;
         wdata_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (capture) begin
         rdata_q <= mem_dq_i;
      end
   end

   for (genvar b = 0; b < DW; b++) begin : g_pad
      assign mem_dq_oe[b] = drive;
      assign mem_dq_o[b]  = wdata_q[b];
   end

   assign mem_addr = addr_q;
   assign rdata    = rdata_q;

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
   import sram_bridge_pkg::*;
#(
   parameter int AW    = 18,
   parameter int DW    = 8,
   parameter int T_RD  = 1,
   parameter int T_WLZ = 1,
   parameter int T_DS  = 1,
   parameter int T_HZ  = 1,
   parameter int T_WP  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          ack,
   output logic [DW-1:0] rdata,
   output logic          rvalid,
   output logic [AW-1:0] mem_addr,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [DW-1:0] mem_dq_o,
   output logic [DW-1:0] mem_dq_oe,
   input  logic [DW-1:0] mem_dq_i
);

   pin_ctl_t pins;
   logic     accept, capture;

   sram_bridge_seq #(
      .T_RD (T_RD),
      .T_WLZ(T_WLZ),
      .T_DS (T_DS),
      .T_HZ (T_HZ),
      .T_WP (T_WP)
   ) i_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .req_we (we),
      .accept (accept),
      .capture(capture),
      .pins   (pins),
      .ack    (ack),
      .rvalid (rvalid)
   );

   sram_bridge_dpath #(
      .AW(AW),
      .DW(DW)
   ) i_dpath (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .capture  (capture),
      .drive    (pins.drive),
      .addr     (addr),
      .wdata    (wdata),
      .mem_dq_i (mem_dq_i),
      .mem_addr (mem_addr),
      .mem_dq_o (mem_dq_o),
      .mem_dq_oe(mem_dq_oe),
      .rdata    (rdata)
   );

   assign mem_ce_n = pins.ce_n;
   assign mem_oe_n = pins.oe_n;
   assign mem_we_n = pins.we_n;

   assert_float_on_we_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> (mem_dq_oe == '0));

   assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   assert_no_drive_while_reading_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_dq_oe == '0));

endmodule

// File: tb/test_sram_bridge.sv
`timescale 1ns/1ps
module test_sram_bridge;

   localparam int T_RD  = 2;
   localparam int T_WLZ = 1;
   localparam int T_DS  = 2;
   localparam int T_HZ  = 1;
   localparam int T_WP  = 3;
   localparam int NV    = 8;

   // {write, addr[17:0], data[7:0]}; for reads data is the expected value
   localparam logic [26:0] VEC [NV] = '{
      {1'b1, 18'h00011, 8'hA5},
      {1'b1, 18'h3FF22, 8'h3C},
      {1'b1, 18'h2AA33, 8'hC3},
      {1'b0, 18'h00011, 8'hA5},
      {1'b0, 18'h3FF22, 8'h3C},
      {1'b1, 18'h00011, 8'h7E},
      {1'b0, 18'h00011, 8'h7E},
      {1'b0, 18'h2AA33, 8'hC3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0;
   logic [17:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        ack, rvalid, mem_ce_n, mem_oe_n, mem_we_n;
   logic [7:0]  rdata, mem_dq_o, mem_dq_oe, mem_dq_i;
   logic [17:0] mem_addr;

   always #4 clk = ~clk;

   sram_bridge #(.T_RD(T_RD), .T_WLZ(T_WLZ), .T_DS(T_DS), .T_HZ(T_HZ), .T_WP(T_WP)) i_sram_bridge (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .ack(ack), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   // RAM model, indexed by the low address byte (test addresses differ there)
   logic [7:0] store [256];
   assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n) ? store[mem_addr[7:0]] : 8'h00;

   int tot_a = 0, bad_a = 0, tot_m = 0, bad_m = 0;
   bit cur_we = 1'b0;
   logic [7:0] cur_exp = '0;
   int gap_seen = 0;

   task automatic chk(inout int t, inout int b, input bit ok, input string tag,
                      input longint act, input longint exp);
      t++;
      if (!ok) begin
         b++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: per-access timing, RAM write commit, protocol rules
   bit         prev_ce_n = 1'b1, prev_we_n = 1'b1, prev_ack = 1'b0, mon_we = 1'b0;
   logic [17:0] prev_addr = '0;
   logic [7:0]  mon_exp = '0, last_dq = '0, last_rd = '0;
   bit          last_full = 1'b0, early = 1'b0;
   int ce_cnt = 0, oe_cnt = 0, we_cnt = 0, drv_cnt = 0, hi_run = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) store[i] = 8'(i) ^ 8'h5A;
         prev_ce_n = 1'b1; prev_we_n = 1'b1; prev_ack = 1'b0; hi_run = 0;
      end else begin
         if (!mem_ce_n) begin
            if (prev_ce_n) begin
               gap_seen = hi_run; hi_run = 0;
               mon_we = cur_we; mon_exp = cur_exp;
               ce_cnt = 0; oe_cnt = 0; we_cnt = 0; drv_cnt = 0; early = 1'b0;
            end else begin
               chk(tot_m, bad_m, mem_addr == prev_addr, "R8 address held", mem_addr, prev_addr);
            end
            ce_cnt++;
            if (!mem_oe_n) oe_cnt++;
            if (!mem_we_n) begin
               if (we_cnt < T_WLZ && mem_dq_oe != 8'h00) early = 1'b1;
               we_cnt++;
               last_dq = mem_dq_o;
               last_full = (mem_dq_oe == 8'hFF);
            end
            if (mem_dq_oe != 8'h00) drv_cnt++;
            chk(tot_m, bad_m, !(!mem_oe_n && !mem_we_n), "R4 oe/we overlap", {mem_oe_n, mem_we_n}, 2'b10);
         end else begin
            hi_run++;
            chk(tot_m, bad_m, mem_oe_n && mem_we_n && mem_dq_oe == 8'h00, "R2 standby pins",
                {mem_oe_n, mem_we_n, mem_dq_oe}, {2'b11, 8'h00});
         end
         if (!prev_ce_n && !prev_we_n && (mem_ce_n || mem_we_n)) begin
            chk(tot_m, bad_m, last_full, "R5 data driven at write end", last_full, 1);
            store[prev_addr[7:0]] = last_dq;
         end
         if (prev_ack) chk(tot_m, bad_m, !ack, "R6 ack single pulse", ack, 0);
         if (ack) begin
            if (mon_we) begin
               chk(tot_m, bad_m, ce_cnt == T_WLZ + T_DS + 1, "R4 write ce low cycles", ce_cnt, T_WLZ + T_DS + 1);
               chk(tot_m, bad_m, we_cnt == T_WLZ + T_DS, "R4 write we low cycles", we_cnt, T_WLZ + T_DS);
               chk(tot_m, bad_m, oe_cnt == 0, "R4 oe during write", oe_cnt, 0);
               chk(tot_m, bad_m, drv_cnt == T_DS + 1, "R5 driven cycles", drv_cnt, T_DS + 1);
               chk(tot_m, bad_m, !early, "R5 drive before float time", early, 0);
               chk(tot_m, bad_m, !rvalid, "R6 rvalid on write ack", rvalid, 0);
               chk(tot_m, bad_m, rdata == last_rd, "R9 rdata held over write", rdata, last_rd);
            end else begin
               chk(tot_m, bad_m, ce_cnt == T_RD && oe_cnt == T_RD, "R3 read ce/oe cycles", {ce_cnt, oe_cnt}, {T_RD, T_RD});
               chk(tot_m, bad_m, we_cnt == 0, "R3 we during read", we_cnt, 0);
               chk(tot_m, bad_m, rvalid, "R3 rvalid with ack", rvalid, 1);
               chk(tot_m, bad_m, rdata == mon_exp, "R3 read data", rdata, mon_exp);
               last_rd = mon_exp;
            end
         end
         prev_ce_n = mem_ce_n; prev_we_n = mem_we_n; prev_addr = mem_addr; prev_ack = ack;
      end
   end

   task automatic do_op(input bit w, input logic [17:0] a, input logic [7:0] d, input bit b2b);
      cur_we = w; cur_exp = d;
      req = 1'b1; we = w; addr = a; wdata = d;
      do begin
         @(negedge clk);
         if (!mem_ce_n) begin   // R8: scramble the request mid-access
            addr = ~a; wdata = ~d;
         end
      end while (!ack);
      if (!b2b) begin
         req = 1'b0;
         @(negedge clk);
      end
   endtask

   bit wd = 1'b0;

   initial begin
      fork
         begin
            repeat (3) begin
               @(negedge clk);
               chk(tot_a, bad_a, mem_ce_n && mem_oe_n && mem_we_n && mem_dq_oe == 8'h00 && !ack && !rvalid,
                   "R1 reset outputs", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, ack, rvalid}, {3'b111, 8'h00, 2'b00});
            end
            rst_n = 1'b1;
            repeat (2) @(negedge clk);
            for (int i = 0; i < NV; i++) begin
               do_op(VEC[i][26], VEC[i][25:8], VEC[i][7:0], 1'b0);
            end
            // R7: back-to-back pairs
            do_op(1'b0, 18'h3FF22, 8'h3C, 1'b1);
            do_op(1'b1, 18'h12344, 8'h99, 1'b1);
            chk(tot_a, bad_a, gap_seen == T_HZ + 2, "R7 read-to-write gap", gap_seen, T_HZ + 2);
            do_op(1'b0, 18'h12344, 8'h99, 1'b1);
            chk(tot_a, bad_a, gap_seen == 2, "R7 write-to-read gap", gap_seen, 2);
            do_op(1'b0, 18'h00011, 8'h7E, 1'b0);
            chk(tot_a, bad_a, gap_seen == 2, "R7 read-to-read gap", gap_seen, 2);
            // R9: rdata unchanged by a later write, seen at the port
            do_op(1'b1, 18'h2AA33, 8'h18, 1'b0);
            repeat (2) @(negedge clk);
            chk(tot_a, bad_a, rdata == 8'h7E, "R9 rdata after write", rdata, 8'h7E);
            do_op(1'b0, 18'h2AA33, 8'h18, 1'b0);
            chk(tot_a, bad_a, rdata == 8'h18, "R8 latched write data read back", rdata, 8'h18);
         end
         begin
            repeat (50000) @(posedge clk);
            wd = 1'b1;
         end
      join_any
      disable fork;
      if (wd) begin
         bad_a++; tot_a++;
         $display("FAIL watchdog actual=expired expected=done");
      end
      $display("test done: total=%0d bad=%0d", tot_a + tot_m, bad_a + bad_m);
      $finish;
   end

endmodule